// File: doc/BRIEF.md
# Successive-Approximation ADC Controller

This block is the digital side of a multiplexed successive-approximation converter with up to six analog inputs. Software reaches it through a simple APB-style register bus. To take a sample it programs a settle delay, then writes the control word with a channel number, the power bit and, if wanted, the interrupt enable. After the delay the block runs a bit-serial binary search, MSB first. It drives a trial code toward an external DAC and reads back a one-bit comparator decision for each bit.

When the last bit is decided, the result goes into the data register, right-aligned. The block then drops its busy flag and sets a sticky completion flag, which drives a level interrupt when enabled. Software acknowledges by writing the control word to zero. That write also powers the converter down and cancels any sample still running. The analog parts are outside the block, and a single clock serves both the bus and the converter.

Top module: `sar_adc_ctrl`

## Requirements
- R1: Registers sit at byte offsets 0x00 (result), 0x04 (status), 0x08 (control) and 0x0C (settle delay). Read data is combinational on the address. Any other offset reads zero, and a write to it changes no register.
- R2: The delay register keeps only bits [5:0] of a write and reads them back with the upper bits zero. It is sampled when a sample starts, so a later write affects only the next sample.
- R3: The result has RES bits (default 10) and reads back right-aligned with the upper bits zero. Bits are tried MSB first, one clock each. A trial bit is kept when the comparator input is 1 (input at or above the trial code), so an input above full scale gives the all-ones code.
- R4: A start with a channel field (control bits [2:0]) of 6 or 7 is refused: busy stays 0 and the completion flag is not set.
- R5: A sample starts only when a control write changes the power bit (bit 3) from 0 to 1. The channel is captured at that moment and driven on the channel output. Control writes while a sample runs do not change the channel in use, and they do not restart the sample.
- R6: Status bit 0 (busy) reads 1 for exactly DLY+RES cycles after the starting write, where DLY is the delay register value. A DLY of 0 puts the first trial out on the cycle after the write.
- R7: At completion, control bit 6 (completion flag) is set whether or not bit 5 (interrupt enable) is set. The irq output equals flag AND enable.
- R8: A control write with bit 3 at 0 powers the converter down and cancels a running sample, leaving the result register unchanged. A control write with bit 6 at 0 clears the completion flag, so writing zero clears both.
- R9: After reset every register reads zero, irq is 0 and the power output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for bus and converter |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus select |
| bus_enable | input | 1 | Bus access phase |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | AW (5) | Byte offset |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data |
| adc_power | output | 1 | Converter power enable (control bit 3) |
| adc_chan | output | 3 | Channel captured at start |
| adc_trial | output | RES (10) | Trial code for the external DAC |
| adc_cmp_hi | input | 1 | Comparator: 1 when input is at or above the trial code |
| irq | output | 1 | Level interrupt |

## Verification
A control write takes effect at the clock edge that ends its access phase. From that edge, busy is high at the next DLY+RES sampling points. The result and completion flag appear right after the last of these, and irq follows the flag in the same cycle because it is combinational. The bench keeps a behavioural model that is advanced at every rising edge from the bus values it drove. It compares every output and the read data at the following falling edge, so each result is checked in exactly the cycle it is due. It also counts busy cycles directly and reads registers back at the access-phase falling edge.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int CH_W    = 3;
  localparam int BIT_PWR = 3;
  localparam int BIT_IE  = 5;
  localparam int BIT_IS  = 6;
  localparam logic [7:0] OFS_RES  = 8'h00;
  localparam logic [7:0] OFS_STAT = 8'h04;
  localparam logic [7:0] OFS_CTRL = 8'h08;
  localparam logic [7:0] OFS_DLY  = 8'h0C;
  typedef enum logic [1:0] {PH_IDLE, PH_WAIT, PH_CONV} phase_t;
endpackage

// File: rtl/sar_wait.sv
module sar_wait #(
  parameter int DLY_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             clr,
  input  logic [DLY_W-1:0] val,
  output logic             running,
  output logic             expire
);
  logic [DLY_W-1:0] cnt;

  assign expire = running && (cnt == DLY_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      running <= 1'b0;
    end else if (clr) begin
      cnt     <= '0;
      running <= 1'b0;
    end else if (load) begin
      cnt     <= val;
      running <= (val != '0);
    end else if (running) begin
      cnt <= cnt - DLY_W'(1);
      if (cnt == DLY_W'(1)) running <= 1'b0;
    end
  end

  AST_WAIT_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (running && $past(running)) |-> (cnt + DLY_W'(1) == $past(cnt))); // R6
endmodule

// File: rtl/sar_engine.sv
module sar_engine
  import sar_pkg::*;
#(
  parameter int RES   = 10,
  parameter int DLY_W = 6,
  parameter int NCH   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic [CH_W-1:0]  chan_in,
  input  logic [DLY_W-1:0] dly,
  input  logic             cmp_hi,
  output logic             busy,
  output logic             done,
  output logic [RES-1:0]   result,
  output logic [RES-1:0]   trial,
  output logic [CH_W-1:0]  chan
);
  localparam int IW = (RES > 1) ? $clog2(RES) : 1;
  localparam logic [IW-1:0]  IDX_TOP = IW'(RES - 1);
  localparam logic [RES-1:0] TRIAL0  = {1'b1, {(RES-1){1'b0}}};

  phase_t         phase;
  logic [IW-1:0]  idx;
  logic [RES-1:0] code;
  logic [CH_W-1:0] chan_q;
  logic           wait_run, wait_exp;

  // keep or drop bit i, then raise the next lower bit as the new trial
  function automatic logic [RES-1:0] keep_bit(input logic [RES-1:0] c,
                                              input logic [IW-1:0] i,
                                              input logic b);
    logic [RES-1:0] r;
    r = c;
    r[i] = b;
    if (i != '0) r[i - 1'b1] = 1'b1;
    return r;
  endfunction

  sar_wait #(.DLY_W(DLY_W)) u_wait (
    .clk(clk), .rst_n(rst_n),
    .load(start && phase == PH_IDLE), .clr(abort), .val(dly),
    .running(wait_run), .expire(wait_exp)
  );

  assign busy   = (phase != PH_IDLE);
  assign done   = (phase == PH_CONV) && (idx == '0) && !abort;
  assign result = keep_bit(code, '0, cmp_hi);
  assign trial  = code;
  assign chan   = chan_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      idx    <= '0;
      code   <= '0;
      chan_q <= '0;
    end else if (abort) begin
      phase <= PH_IDLE;
      code  <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (start) begin
          chan_q <= chan_in;
          if (dly == '0) begin
            phase <= PH_CONV;
            idx   <= IDX_TOP;
            code  <= TRIAL0;
          end else begin
            phase <= PH_WAIT;
          end
        end
        PH_WAIT: if (wait_exp) begin
          phase <= PH_CONV;
          idx   <= IDX_TOP;
          code  <= TRIAL0;
        end
        PH_CONV: begin
          code <= keep_bit(code, idx, cmp_hi);
          if (idx == '0) phase <= PH_IDLE;
          else           idx   <= idx - 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  AST_BIT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_CONV && $past(phase == PH_CONV)) |-> (idx + 1'b1 == $past(idx))); // R3
  AST_CHAN_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (chan_q < CH_W'(NCH))); // R4
  AST_CHAN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(chan_q)); // R5
  AST_WAIT_MATCHES_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    wait_run |-> (phase == PH_WAIT)); // R6
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
  import sar_pkg::*;
#(
  parameter int AW    = 5,
  parameter int DW    = 32,
  parameter int RES   = 10,
  parameter int DLY_W = 6,
  parameter int NCH   = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_sel,
  input  logic            bus_enable,
  input  logic            bus_write,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic            adc_power,
  output logic [CH_W-1:0] adc_chan,
  output logic [RES-1:0]  adc_trial,
  input  logic            adc_cmp_hi,
  output logic            irq
);
  logic [CH_W-1:0]  ch_q;
  logic             pwr_q, ie_q, is_q;
  logic [DLY_W-1:0] dly_q;
  logic [RES-1:0]   res_q;
  logic             eng_busy, eng_done;
  logic [RES-1:0]   eng_result;

  wire acc_wr    = bus_sel && bus_enable && bus_write;
  wire wr_ctrl   = acc_wr && (bus_addr == OFS_CTRL[AW-1:0]);
  wire wr_dly    = acc_wr && (bus_addr == OFS_DLY[AW-1:0]);
  wire chan_ok   = bus_wdata[CH_W-1:0] < CH_W'(NCH);
  wire eng_start = wr_ctrl && bus_wdata[BIT_PWR] && !pwr_q && !eng_busy && chan_ok;
  wire eng_abort = wr_ctrl && !bus_wdata[BIT_PWR];

  sar_engine #(.RES(RES), .DLY_W(DLY_W), .NCH(NCH)) u_eng (
    .clk(clk), .rst_n(rst_n),
    .start(eng_start), .abort(eng_abort),
    .chan_in(bus_wdata[CH_W-1:0]), .dly(dly_q), .cmp_hi(adc_cmp_hi),
    .busy(eng_busy), .done(eng_done), .result(eng_result),
    .trial(adc_trial), .chan(adc_chan)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_q  <= '0;
      pwr_q <= 1'b0;
      ie_q  <= 1'b0;
      is_q  <= 1'b0;
      dly_q <= '0;
      res_q <= '0;
    end else begin
      if (wr_ctrl) begin
        ch_q  <= bus_wdata[CH_W-1:0];
        pwr_q <= bus_wdata[BIT_PWR];
        ie_q  <= bus_wdata[BIT_IE];
      end
      if (eng_done)                          is_q <= 1'b1;
      else if (wr_ctrl && !bus_wdata[BIT_IS]) is_q <= 1'b0;
      if (eng_done) res_q <= eng_result;
      if (wr_dly)   dly_q <= bus_wdata[DLY_W-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == OFS_RES[AW-1:0]) begin
      bus_rdata[RES-1:0] = res_q;
    end else if (bus_addr == OFS_STAT[AW-1:0]) begin
      bus_rdata[0] = eng_busy;
    end else if (bus_addr == OFS_CTRL[AW-1:0]) begin
      bus_rdata[CH_W-1:0] = ch_q;
      bus_rdata[BIT_PWR]  = pwr_q;
      bus_rdata[BIT_IE]   = ie_q;
      bus_rdata[BIT_IS]   = is_q;
    end else if (bus_addr == OFS_DLY[AW-1:0]) begin
      bus_rdata[DLY_W-1:0] = dly_q;
    end
  end

  assign adc_power = pwr_q;
  assign irq       = is_q && ie_q;

  AST_DONE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> is_q); // R7
  AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    eng_abort |=> !eng_busy); // R8
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> eng_busy); // R5
  AST_BUSY_NEEDS_POWER: assert property (@(posedge clk) disable iff (!rst_n)
    eng_busy |-> pwr_q); // R8
endmodule

// File: tb/tb_sar_adc_ctrl.sv
`timescale 1ns/1ps
module tb_sar_adc_ctrl;
  localparam int AW = 5, DW = 32, RES = 10, NCH = 6;
  localparam int MAXV = (1 << RES) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 0, bus_enable = 0, bus_write = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic adc_power, adc_cmp_hi, irq;
  logic [2:0] adc_chan;
  logic [RES-1:0] adc_trial;
  int vin [8];
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  assign adc_cmp_hi = (vin[adc_chan] >= int'(adc_trial));

  sar_adc_ctrl #(.AW(AW), .DW(DW), .RES(RES), .NCH(NCH)) dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_enable(bus_enable),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .adc_power(adc_power), .adc_chan(adc_chan),
    .adc_trial(adc_trial), .adc_cmp_hi(adc_cmp_hi), .irq(irq)
  );

  // behavioural model, advanced at each rising edge
  int m_left, m_data, m_dly, m_ch, m_cf;
  bit m_pwr, m_ie, m_is;

  always @(posedge clk) begin
    bit cw, ab, dn;
    if (!rst_n) begin
      m_left = 0; m_data = 0; m_dly = 0; m_ch = 0; m_cf = 0;
      m_pwr = 0; m_ie = 0; m_is = 0;
    end else begin
      cw = bus_sel && bus_enable && bus_write && bus_addr == 5'h08;
      ab = cw && !bus_wdata[3];
      dn = (m_left == 1) && !ab;
      if (m_left > 0) m_left = m_left - 1;
      if (ab) m_left = 0;
      if (dn) begin
        m_data = (vin[m_ch] > MAXV) ? MAXV : vin[m_ch];
        m_is = 1;
      end
      if (cw) begin
        if (bus_wdata[3] && !m_pwr && int'(bus_wdata[2:0]) < NCH) begin
          m_left = m_dly + RES;
          m_ch = int'(bus_wdata[2:0]);
        end
        if (!bus_wdata[6] && !dn) m_is = 0;
        m_pwr = bus_wdata[3]; m_ie = bus_wdata[5]; m_cf = int'(bus_wdata[2:0]);
      end
      if (bus_sel && bus_enable && bus_write && bus_addr == 5'h0C)
        m_dly = int'(bus_wdata[5:0]);
    end
  end

  function automatic int model_read(input int a);
    case (a)
      0:  return m_data;
      4:  return (m_left > 0) ? 1 : 0;
      8:  return (int'(m_is) << 6) | (int'(m_ie) << 5) | (int'(m_pwr) << 3) | m_cf;
      12: return m_dly;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R7 irq", int'(irq), int'(m_is && m_ie));
      chk("R8 power", int'(adc_power), int'(m_pwr));
      chk("R5 channel", int'(adc_chan), m_ch);
      chk("R1 rdata", int'(bus_rdata), model_read(int'(bus_addr)));
    end
  end

  task automatic wr(input int a, input int d);
    @(posedge clk); #1;
    bus_sel = 1; bus_enable = 0; bus_write = 1;
    bus_addr = AW'(a); bus_wdata = DW'(d);
    @(posedge clk); #1 bus_enable = 1;
    @(posedge clk); #1 bus_sel = 0; bus_enable = 0; bus_write = 0;
  endtask

  task automatic rd(input int a, input int exp, input string tag);
    @(posedge clk); #1;
    bus_sel = 1; bus_enable = 0; bus_write = 0; bus_addr = AW'(a);
    @(posedge clk); #1 bus_enable = 1;
    @(negedge clk) chk(tag, int'(bus_rdata), exp);
    @(posedge clk); #1 bus_sel = 0; bus_enable = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  // start a sample and count the sampling points with busy high
  task automatic busy_len(input int ctrl, input int exp, input string tag);
    int n = 0;
    wr(8, ctrl);
    bus_addr = AW'(4);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (bus_rdata[0]) n++;
      else break;
    end
    chk(tag, n, exp);
  endtask

  initial begin
    #(5.0 * 100000);
    errors++; checks++;
    $display("FAIL R6 watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    vin[0] = 0; vin[1] = 2000; vin[2] = 517; vin[3] = 1023;
    vin[4] = 300; vin[5] = 768; vin[6] = 5; vin[7] = 5;
    idle(3); rst_n = 1; idle(2);
    // R9 reset state
    rd(0, 0, "R9 result"); rd(4, 0, "R9 status");
    rd(8, 0, "R9 control"); rd(12, 0, "R9 delay");
    chk("R9 irq", int'(irq), 0);
    // R2 delay write, R3 conversion of channel 2 with irq enabled
    wr(12, 8); rd(12, 8, "R2 delay readback");
    wr(8, 'h2A); rd(4, 1, "R6 busy during sample");
    idle(25);
    rd(0, 517, "R3 result ch2");
    rd(8, 'h6A, "R7 flag set with enable");
    chk("R7 irq high", int'(irq), 1);
    // R8 clear by writing zero
    wr(8, 0); rd(8, 0, "R8 control cleared");
    chk("R8 irq low", int'(irq), 0);
    // R6 zero delay, R3 clipping to full scale
    wr(12, 0);
    busy_len('h29, RES, "R6 busy length dly0");
    idle(2); rd(0, MAXV, "R3 clip ch1");
    wr(8, 0); wr(12, 5);
    busy_len('h28, 5 + RES, "R6 busy length dly5");
    idle(2); rd(0, 0, "R3 zero input ch0");
    wr(8, 0);
    // R2 mask
    wr(12, 'hFF); rd(12, 'h3F, "R2 delay masked");
    wr(12, 3);
    // R4 out of range channel
    wr(8, 'h2E); idle(20);
    rd(4, 0, "R4 no busy ch6"); rd(8, 'h2E, "R4 no flag ch6");
    wr(8, 0); wr(8, 'h0F); idle(20);
    rd(8, 'h0F, "R4 no flag ch7");
    wr(8, 0);
    // R7 enable off: flag set, irq low
    wr(8, 'h0B); idle(20);
    rd(0, 1023, "R3 result ch3");
    rd(8, 'h4B, "R7 flag without enable");
    chk("R7 irq masked", int'(irq), 0);
    wr(8, 0);
    // R5 channel change while busy has no effect
    wr(8, 'h2C); wr(8, 'h2D);
    chk("R5 channel held", int'(adc_chan), 4);
    idle(20);
    rd(0, 300, "R5 result from captured channel");
    rd(4, 0, "R5 no restart");
    // R8 abort mid-sample leaves result
    wr(8, 0); wr(8, 'h2D); idle(4); wr(8, 0);
    rd(4, 0, "R8 abort idle");
    rd(0, 300, "R8 result kept");
    idle(20);
    rd(8, 0, "R8 no flag after abort");
    // R5 power must fall before a new start; then ch5
    wr(12, 0); wr(8, 'h2D); idle(14);
    rd(0, 768, "R5 fresh start ch5");
    // R1 unmapped offsets
    wr(16, 'hFFFF);
    rd(16, 0, "R1 unmapped read");
    rd(12, 0, "R1 delay untouched");
    rd(8, 'h6D, "R1 control untouched");
    rd(20, 0, "R1 unmapped read 0x14");
    idle(2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule